// File: doc/BRIEF.md
# Automatic Reseed Scheduler

This block decides when a random generator has to refresh its seed without being told to by software. It holds two reload values. The request limit counts completed generate operations. The age limit counts ticks from a prescaler. When either count runs out, the block asks for a reseed with a one-cycle pulse on its output. A reload value of zero switches that count off.

Both counters restart from their reload values whenever a reseed finishes or either counter fires. Writing a reload value also restarts its own counter at once. While a reseed is already in progress, a trigger is not lost. It is stored as a single pending request and issued in the first cycle the generator is idle again. Deciding between this request and commands from software is left to the surrounding logic.

Top module: `rsd_auto_reseed`

## Requirements
- R1: After reset both reload values are zero. Generate completions and ticks then produce no `reseed_req` pulse until a reload value is written.
- R2: With request limit N (N > 0), `reseed_req` is high in the cycle after the N-th `gen_done` pulse counted since the last reload. It is high for that one cycle only.
- R3: With age limit N (N > 0), `reseed_req` is high in the cycle after the N-th cycle in which `tick` is high, counted since the last reload. Cycles without `tick` do not count.
- R4: A reload value of zero disables its counter. That counter never causes a pulse, however many events arrive.
- R5: When either counter fires, both counters restart from their reload values.
- R6: A `seed_done` pulse restarts both counters from their reload values.
- R7: A write with `cfg_wr_en` high loads `cfg_wr_data` as a reload value and restarts that counter. `cfg_sel` = 0 selects the request limit and `cfg_sel` = 1 selects the age limit. An event for the selected counter in the same cycle is ignored.
- R8: A trigger in a cycle with `seed_busy` high gives no pulse while `seed_busy` stays high. The trigger is held and issued in the cycle after the first cycle with `seed_busy` low. Several triggers during one busy period give one pulse.
- R9: If both counters fire in the same cycle, exactly one one-cycle pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for a reload value |
| cfg_sel | input | 1 | Selects the reload value to write: 0 = request limit, 1 = age limit |
| cfg_wr_data | input | CNT_W | Reload value to write |
| gen_done | input | 1 | One-cycle pulse marking a completed generate |
| seed_done | input | 1 | One-cycle pulse marking a completed reseed of any origin |
| seed_busy | input | 1 | High while a reseed is in progress |
| tick | input | 1 | Prescaled time base for the age counter |
| reseed_req | output | 1 | One-cycle automatic reseed request |

## Verification
Some rules are checked by the assertions on every cycle:
- No counter ever holds a value above its reload value, and a zero reload keeps its counter at zero.
- A write or a `seed_done` leaves the counters at their reload values in the next cycle.
- No request leaves the block in the cycle after a busy cycle.
- A held request is issued as soon as `seed_busy` falls.

Other behaviour shows only at the ports during the bench scenarios:
- The exact count at which a pulse appears, for every reload value of a narrow configuration.
- The cross-restart between the two counters.
- A write that swallows a same-cycle event.
- Several triggers during one busy period merging into a single pulse.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
   localparam int unsigned RSD_NCH = 2;

   typedef enum logic [0:0] {
      RSD_CH_REQ = 1'b0,
      RSD_CH_AGE = 1'b1
   } rsd_chan_e;
endpackage

// File: rtl/rsd_reload_counter.sv
module rsd_reload_counter #(
   parameter int unsigned CNT_W   = 16,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_wr,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             restart,
   input  logic             step,
   output logic             fire,
   output logic [CNT_W-1:0] rld_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] rld_q, cnt_q;

   // a write in the same cycle swallows this counter's event
   assign fire = step && !ld_wr && (rld_q != '0) && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_q <= RST_VAL;
         cnt_q <= RST_VAL;
      end else if (ld_wr) begin
         rld_q <= ld_val;
         cnt_q <= ld_val;
      end else if (restart) begin
         cnt_q <= rld_q;
      end else if (step && (cnt_q != '0)) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign rld_o = rld_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/rsd_req_hold.sv
module rsd_req_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic busy,
   output logic req,
   output logic pend
);
   logic pend_q, req_q;
   logic want;

   assign want = trig || pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         pend_q <= want && busy;
         req_q  <= want && !busy;
      end
   end

   assign req  = req_q;
   assign pend = pend_q;
endmodule

// File: rtl/rsd_auto_reseed.sv
module rsd_auto_reseed #(
   parameter int unsigned CNT_W = 16,
   parameter logic [CNT_W-1:0] REQ_RST_VAL = '0,
   parameter logic [CNT_W-1:0] AGE_RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic             cfg_sel,
   input  logic [CNT_W-1:0] cfg_wr_data,
   input  logic             gen_done,
   input  logic             seed_done,
   input  logic             seed_busy,
   input  logic             tick,
   output logic             reseed_req
);
   import rsd_pkg::*;

   localparam int unsigned NCH = RSD_NCH;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("rsd_auto_reseed: CNT_W must lie in 2..32");
   end

   logic [NCH-1:0]   ev_vec, fire_vec, wr_vec;
   logic [CNT_W-1:0] cnt_vec [NCH];
   logic [CNT_W-1:0] rld_vec [NCH];
   logic             any_fire, restart_all, pend_w;

   assign ev_vec[RSD_CH_REQ] = gen_done;
   assign ev_vec[RSD_CH_AGE] = tick;

   assign any_fire    = |fire_vec;
   assign restart_all = seed_done || any_fire;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam logic [CNT_W-1:0] RST_V = (ch == int'(RSD_CH_REQ)) ? REQ_RST_VAL : AGE_RST_VAL;

      assign wr_vec[ch] = cfg_wr_en && (cfg_sel == 1'(ch));

      rsd_reload_counter #(
         .CNT_W   (CNT_W),
         .RST_VAL (RST_V)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_wr   (wr_vec[ch]),
         .ld_val  (cfg_wr_data),
         .restart (restart_all),
         .step    (ev_vec[ch]),
         .fire    (fire_vec[ch]),
         .rld_o   (rld_vec[ch]),
         .cnt_o   (cnt_vec[ch])
      );
   end

   rsd_req_hold u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (any_fire),
      .busy  (seed_busy),
      .req   (reseed_req),
      .pend  (pend_w)
   );
endmodule

// File: rtl/rsd_auto_reseed_chk.sv
module rsd_auto_reseed_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr_en,
   input logic             cfg_sel,
   input logic [CNT_W-1:0] cfg_wr_data,
   input logic             seed_done,
   input logic             seed_busy,
   input logic             reseed_req,
   input logic             pend,
   input logic [CNT_W-1:0] cnt_req,
   input logic [CNT_W-1:0] rld_req,
   input logic [CNT_W-1:0] cnt_age,
   input logic [CNT_W-1:0] rld_age
);
   p_req_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_req <= rld_req);

   p_age_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_age <= rld_age);

   p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rld_req == '0) |-> (cnt_req == '0));

   p_seed_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_done && !cfg_wr_en) |=> (cnt_req == rld_req) && (cnt_age == rld_age));

   p_wr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && !cfg_sel) |=> (cnt_req == $past(cfg_wr_data)) && (rld_req == $past(cfg_wr_data)));

   p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seed_busy |=> !reseed_req);

   p_held_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !seed_busy) |=> reseed_req);
endmodule

bind rsd_auto_reseed rsd_auto_reseed_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_sel     (cfg_sel),
   .cfg_wr_data (cfg_wr_data),
   .seed_done   (seed_done),
   .seed_busy   (seed_busy),
   .reseed_req  (reseed_req),
   .pend        (pend_w),
   .cnt_req     (cnt_vec[0]),
   .rld_req     (rld_vec[0]),
   .cnt_age     (cnt_vec[1]),
   .rld_age     (rld_vec[1])
);

// File: tb/rsd_auto_reseed_bench.sv
module rsd_auto_reseed_bench;
   localparam int W = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         cfg_wr_en = 1'b0, cfg_sel = 1'b0;
   logic [W-1:0] cfg_wr_data = '0;
   logic         gen_done = 1'b0, seed_done = 1'b0, seed_busy = 1'b0, tick = 1'b0;
   logic         reseed_req;
   logic         got;
   int           nvec = 0, nbad = 0;

   rsd_auto_reseed #(.CNT_W(W)) u_rsd_auto_reseed (
      .clk (clk), .rst_n (rst_n), .cfg_wr_en (cfg_wr_en), .cfg_sel (cfg_sel),
      .cfg_wr_data (cfg_wr_data), .gen_done (gen_done), .seed_done (seed_done),
      .seed_busy (seed_busy), .tick (tick), .reseed_req (reseed_req)
   );

   task automatic cyc(input logic we, input logic sel, input logic [W-1:0] d,
                      input logic gd, input logic tk, input logic sd, input logic bz);
      cfg_wr_en = we; cfg_sel = sel; cfg_wr_data = d;
      gen_done = gd; tick = tk; seed_done = sd; seed_busy = bz;
      @(posedge clk); #1;
      got = reseed_req;
      cfg_wr_en = 1'b0; gen_done = 1'b0; tick = 1'b0; seed_done = 1'b0;
   endtask

   task automatic chk(input logic exp, input string tag);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s: reseed_req=%0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic idle(); cyc(0, 0, '0, 0, 0, 0, 0); endtask
   task automatic gd1();  cyc(0, 0, '0, 1, 0, 0, 0); endtask
   task automatic tk1();  cyc(0, 0, '0, 0, 1, 0, 0); endtask
   task automatic wr(input logic sel, input logic [W-1:0] d); cyc(1, sel, d, 0, 0, 0, 0); endtask

   initial begin
      #(20 * 200000);
      nbad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 got = reseed_req; chk(1'b0, "R1 reset");
      rst_n = 1'b1;
      // R1: zero reloads after reset
      for (int k = 0; k < 30; k++) begin
         cyc(0, 0, '0, 1, k[0], 0, 0); chk(1'b0, "R1");
      end
      // R2 / R4: every request limit
      for (int n = 0; n < 16; n++) begin
         wr(0, W'(n)); chk(1'b0, "R7");
         wr(1, '0);    chk(1'b0, "R4");
         for (int k = 1; k <= 20; k++) begin
            gd1(); chk((n != 0) && (k % n == 0), (n == 0) ? "R4" : "R2");
            idle(); chk(1'b0, "R2");
         end
      end
      // R3 / R4: every age limit, with gaps between ticks
      wr(0, '0); chk(1'b0, "R4");
      for (int n = 0; n < 16; n++) begin
         wr(1, W'(n)); chk(1'b0, "R7");
         for (int k = 1; k <= 12; k++) begin
            for (int g = 0; g < k % 3; g++) begin idle(); chk(1'b0, "R3"); end
            tk1(); chk((n != 0) && (k % n == 0), (n == 0) ? "R4" : "R3");
         end
      end
      // R9: simultaneous fire
      wr(0, 4'd2); chk(1'b0, "R9");
      wr(1, 4'd2); chk(1'b0, "R9");
      cyc(0, 0, '0, 1, 1, 0, 0); chk(1'b0, "R9");
      cyc(0, 0, '0, 1, 1, 0, 0); chk(1'b1, "R9");
      idle(); chk(1'b0, "R9");
      gd1(); chk(1'b0, "R9");
      gd1(); chk(1'b1, "R9");
      // R5: cross restart
      wr(0, 4'd5); chk(1'b0, "R5");
      wr(1, 4'd3); chk(1'b0, "R5");
      gd1(); chk(1'b0, "R5");
      gd1(); chk(1'b0, "R5");
      tk1(); chk(1'b0, "R5");
      tk1(); chk(1'b0, "R5");
      tk1(); chk(1'b1, "R3");
      for (int k = 0; k < 4; k++) begin gd1(); chk(1'b0, "R5"); end
      gd1(); chk(1'b1, "R5");
      tk1(); chk(1'b0, "R5");
      tk1(); chk(1'b0, "R5");
      tk1(); chk(1'b1, "R5");
      // R6: seed_done restart
      wr(1, '0);   chk(1'b0, "R6");
      wr(0, 4'd4); chk(1'b0, "R6");
      for (int k = 0; k < 3; k++) begin gd1(); chk(1'b0, "R6"); end
      cyc(0, 0, '0, 0, 0, 1, 0); chk(1'b0, "R6");
      for (int k = 0; k < 3; k++) begin gd1(); chk(1'b0, "R6"); end
      gd1(); chk(1'b1, "R6");
      // R7: rewrite restarts; same-cycle event swallowed
      wr(0, 4'd3); chk(1'b0, "R7");
      gd1(); chk(1'b0, "R7");
      gd1(); chk(1'b0, "R7");
      wr(0, 4'd3); chk(1'b0, "R7");
      gd1(); chk(1'b0, "R7");
      gd1(); chk(1'b0, "R7");
      gd1(); chk(1'b1, "R7");
      cyc(1, 0, 4'd2, 1, 0, 0, 0); chk(1'b0, "R7");
      gd1(); chk(1'b0, "R7");
      gd1(); chk(1'b1, "R7");
      // R8: hold while busy, single pending
      wr(0, 4'd1); chk(1'b0, "R8");
      cyc(0, 0, '0, 1, 0, 0, 1); chk(1'b0, "R8");
      cyc(0, 0, '0, 0, 0, 0, 1); chk(1'b0, "R8");
      cyc(0, 0, '0, 1, 0, 0, 1); chk(1'b0, "R8");
      cyc(0, 0, '0, 0, 0, 0, 1); chk(1'b0, "R8");
      idle(); chk(1'b1, "R8");
      idle(); chk(1'b0, "R8");
      idle(); chk(1'b0, "R8");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule